// File: doc/BRIEF.md
# Scalar Compare and Immediate Unit

This unit is one execute stage of a scalar pipeline. It evaluates comparisons that produce nothing except a one-bit condition flag, and operations that combine a 16-bit immediate with the current value of a destination register. The issue logic presents a 6-bit operation word, the operands, the current destination value, the immediate and the present flag together with a valid strobe. One clock later the unit returns the value to write, a write enable and the next flag.

There are four classes of operation. Register compares test src0 against src1 under one of six conditions, signed or unsigned. Immediate compares test the destination value against the sign-extended immediate. Bit tests examine one selected bit of the source, in a 32-bit form or in a 64-bit form that also sees the upper source word. Immediate writes cover move, flag-gated move, add and multiply. Instruction decode and register storage sit in neighbouring blocks.

Top module: `scmp_imm_unit`

## Requirements
- R1: The operation word is op_code[5:4] class (0 register compare, 1 immediate compare, 2 bit test, 3 immediate write), op_code[3] signed, and op_code[2:0] select. For the compare classes, select values 0..5 mean equal, not-equal, greater, greater-or-equal, less and less-or-equal. With op_code[3]=0 a register compare treats src0 (left) and src1 (right) as unsigned.
- R2: With op_code[3]=1 a register compare treats both operands as two's-complement signed.
- R3: Compares and bit tests return wr_en=0 and result=0.
- R4: A bit test with select bit 1 clear reads bit src1[4:0] of src0. With select bit 0 set, the flag is 1 when that bit is 1. With select bit 0 clear, the flag is 1 when that bit is 0.
- R5: A bit test with select bit 1 set uses position src1[5:0]. Positions 32 to 63 read bit (position-32) of src0_hi.
- R6: An immediate compare uses dst_val as the left operand and the sign-extended imm_val as the right operand. Sign extension applies in the unsigned form as well.
- R7: Immediate write select[1:0]=0 (move) writes the sign-extended immediate with wr_en=1.
- R8: Select[1:0]=1 (conditional move) writes the sign-extended immediate when flag_in=1. When flag_in=0 it returns wr_en=0 and result=dst_val.
- R9: Select[1:0]=2 writes dst_val plus the sign-extended immediate, and select[1:0]=3 writes the low 32 bits of dst_val times the sign-extended immediate. Both use wr_en=1.
- R10: Immediate writes return flag_out equal to flag_in.
- R11: Each accepted operation appears one cycle later with out_valid=1. When in_valid=0, the next cycle has out_valid=0 and wr_en=0. Reset clears out_valid, wr_en, flag_out and result.
- R12: Compare select values 6 and 7 give flag_out=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op_code | input | 6 | Class, signed bit and select |
| src0 | input | 32 | Left register operand / bit-test source low word |
| src0_hi | input | 32 | Upper source word for 64-bit bit tests |
| src1 | input | 32 | Right register operand / bit position |
| dst_val | input | 32 | Current destination register value |
| imm_val | input | 16 | Immediate |
| flag_in | input | 1 | Current condition flag |
| out_valid | output | 1 | Result present |
| result | output | 32 | Value to write |
| wr_en | output | 1 | Destination write enable |
| flag_out | output | 1 | Next condition flag |

## Verification
A wrong selection of the operand in the stage, such as src0 used where dst_val belongs or a missing sign extension, shows on flag_out or result in the very next cycle. Each operation is checked against a model at its single-cycle latency. A wrong flag pass-through during immediate writes, or a stray write enable on compares, also shows within that cycle. Vectors that sit on the sign boundary and on bit positions 31, 32 and 63 expose compare and masking faults that ordinary values would hide.

// File: rtl/scmp_pkg.sv
package scmp_pkg;

    localparam int OP_W = 6;

    typedef enum logic [1:0] {
        CLS_REG_CMP  = 2'd0,
        CLS_IMM_CMP  = 2'd1,
        CLS_BIT_TEST = 2'd2,
        CLS_IMM_WR   = 2'd3
    } op_class_e;

    typedef enum logic [2:0] {
        CND_EQ  = 3'd0,
        CND_NE  = 3'd1,
        CND_GT  = 3'd2,
        CND_GE  = 3'd3,
        CND_LT  = 3'd4,
        CND_LE  = 3'd5,
        CND_RS6 = 3'd6,
        CND_RS7 = 3'd7
    } cond_e;

    typedef enum logic [1:0] {
        WR_MOV  = 2'd0,
        WR_CMOV = 2'd1,
        WR_ADD  = 2'd2,
        WR_MUL  = 2'd3
    } wr_kind_e;

    typedef struct packed {
        op_class_e  cls;
        logic       is_signed;
        logic [2:0] sel;
    } op_word_t;

    // Map equality and ordering onto one condition code.
    function automatic logic cond_hit(cond_e c, logic eq, logic lt);
        case (c)
            CND_EQ:  return eq;
            CND_NE:  return !eq;
            CND_GT:  return !eq && !lt;
            CND_GE:  return !lt;
            CND_LT:  return lt;
            CND_LE:  return lt || eq;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/scmp_cond.sv
module scmp_cond
    import scmp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         is_signed,
    input  cond_e        cond,
    output logic         hit
);
    logic [W-1:0] lhs_k;
    logic [W-1:0] rhs_k;
    logic         eq;
    logic         lt;

    // Flipping the sign bits turns a signed order into an unsigned one.
    always_comb begin
        lhs_k = {lhs[W-1] ^ is_signed, lhs[W-2:0]};
        rhs_k = {rhs[W-1] ^ is_signed, rhs[W-2:0]};
        eq    = (lhs == rhs);
        lt    = (lhs_k < rhs_k);
        hit   = cond_hit(cond, eq, lt);
    end

    always_comb begin
        assert_eq_ne_excl_R1: assert (!(hit && eq && cond == CND_NE));
    end
endmodule

// File: rtl/scmp_bittest.sv
module scmp_bittest #(
    parameter int W       = 32,
    parameter bit WIDE_EN = 1'b1,
    localparam int PW     = $clog2(W)
) (
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  logic [PW:0]  pos,
    input  logic         wide,
    input  logic         want_one,
    output logic         hit
);
    logic [2*W-1:0] word;
    logic [PW:0]    idx;
    logic           bitv;

    generate
        if (WIDE_EN) begin : g_wide
            assign idx = wide ? pos : {1'b0, pos[PW-1:0]};
        end else begin : g_narrow
            assign idx = {1'b0, pos[PW-1:0] | {PW{1'b0 & wide}}};
        end
    endgenerate

    always_comb begin
        word = {hi, lo};
        bitv = word[idx];
        hit  = (bitv == want_one);
    end
endmodule

// File: rtl/scmp_immwr.sv
module scmp_immwr
    import scmp_pkg::*;
#(
    parameter int W  = 32,
    parameter int IW = 16
) (
    input  logic [W-1:0]  dst,
    input  logic [IW-1:0] imm,
    input  wr_kind_e      kind,
    input  logic          flag,
    output logic [W-1:0]  value,
    output logic          wen,
    output logic [W-1:0]  imm_x
);
    always_comb begin
        imm_x = {{(W-IW){imm[IW-1]}}, imm};
        value = imm_x;
        wen   = 1'b1;
        case (kind)
            WR_MOV:  value = imm_x;
            WR_CMOV: begin
                value = flag ? imm_x : dst;
                wen   = flag;
            end
            WR_ADD:  value = dst + imm_x;
            WR_MUL:  value = dst * imm_x;
            default: value = imm_x;
        endcase
    end
endmodule

// File: rtl/scmp_imm_unit.sv
module scmp_imm_unit
    import scmp_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 16,
    parameter bit WIDE_EN = 1'b1,
    localparam int PW     = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic [DATA_W-1:0] src0,
    input  logic [DATA_W-1:0] src0_hi,
    input  logic [DATA_W-1:0] src1,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [IMM_W-1:0]  imm_val,
    input  logic              flag_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic              flag_out
);
    op_word_t          op_w;
    logic [DATA_W-1:0] cmp_lhs;
    logic [DATA_W-1:0] cmp_rhs;
    logic [DATA_W-1:0] imm_x;
    logic [DATA_W-1:0] wr_value;
    logic              wr_wen;
    logic              cmp_hit;
    logic              bt_hit;
    logic [DATA_W-1:0] nxt_result;
    logic              nxt_wen;
    logic              nxt_flag;

    assign op_w = op_word_t'(op_code);

    // Immediate compares put the destination on the left, immediate on the right.
    assign cmp_lhs = (op_w.cls == CLS_IMM_CMP) ? dst_val : src0;
    assign cmp_rhs = (op_w.cls == CLS_IMM_CMP) ? imm_x   : src1;

    scmp_cond #(.W(DATA_W)) u_cond (
        .lhs       (cmp_lhs),
        .rhs       (cmp_rhs),
        .is_signed (op_w.is_signed),
        .cond      (cond_e'(op_w.sel)),
        .hit       (cmp_hit)
    );

    scmp_bittest #(.W(DATA_W), .WIDE_EN(WIDE_EN)) u_bit (
        .lo       (src0),
        .hi       (src0_hi),
        .pos      (src1[PW:0]),
        .wide     (op_w.sel[1]),
        .want_one (op_w.sel[0]),
        .hit      (bt_hit)
    );

    scmp_immwr #(.W(DATA_W), .IW(IMM_W)) u_wr (
        .dst   (dst_val),
        .imm   (imm_val),
        .kind  (wr_kind_e'(op_w.sel[1:0])),
        .flag  (flag_in),
        .value (wr_value),
        .wen   (wr_wen),
        .imm_x (imm_x)
    );

    always_comb begin
        nxt_result = '0;
        nxt_wen    = 1'b0;
        nxt_flag   = flag_in;
        case (op_w.cls)
            CLS_REG_CMP, CLS_IMM_CMP: nxt_flag = cmp_hit;
            CLS_BIT_TEST:             nxt_flag = bt_hit;
            CLS_IMM_WR: begin
                nxt_result = wr_value;
                nxt_wen    = wr_wen;
            end
            default: nxt_flag = flag_in;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            flag_out  <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            wr_en     <= in_valid && nxt_wen;
            if (in_valid) begin
                flag_out <= nxt_flag;
                result   <= nxt_result;
            end
        end
    end

    assert_reset_clear_R11: assert property (@(posedge clk)
        rst |=> (!out_valid && !wr_en && !flag_out));

    assert_latency_R11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !wr_en));

    assert_cmp_no_write_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code[5:4] != 2'd3) |=> (!wr_en && result == '0));

    assert_flag_keep_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code[5:4] == 2'd3) |=> (flag_out == $past(flag_in)));

    assert_cmov_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code[5:4] == 2'd3 && op_code[1:0] == 2'd1 && !flag_in)
        |=> (!wr_en && result == $past(dst_val)));

    assert_mov_sext_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code[5:4] == 2'd3 && op_code[1:0] == 2'd0)
        |=> (wr_en && result == {{(DATA_W-IMM_W){$past(imm_val[IMM_W-1])}}, $past(imm_val)}));

    assert_rsv_cond_R12: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_code[5] && op_code[2:1] == 2'b11) |=> !flag_out);
endmodule

// File: tb/scmp_imm_unit_bench.sv
module scmp_imm_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [5:0]  op_code;
    logic [31:0] src0, src0_hi, src1, dst_val;
    logic [15:0] imm_val;
    logic        flag_in;
    logic        out_valid;
    logic [31:0] result;
    logic        wr_en;
    logic        flag_out;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] r;
        logic        w;
        logic        f;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    scmp_imm_unit u_scmp_imm_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
        .src0(src0), .src0_hi(src0_hi), .src1(src1), .dst_val(dst_val),
        .imm_val(imm_val), .flag_in(flag_in), .out_valid(out_valid),
        .result(result), .wr_en(wr_en), .flag_out(flag_out)
    );

    function automatic logic [5:0] opc(int cls, int sg, int sel);
        return {cls[1:0], sg[0], sel[2:0]};
    endfunction

    function automatic exp_t model(logic [5:0] op, logic [31:0] s0, logic [31:0] s0h,
                                   logic [31:0] s1, logic [31:0] dv, logic [15:0] im,
                                   logic f, string tag);
        exp_t e;
        logic [31:0] sx, l, r;
        logic eq, lt, b;
        int pos;
        sx = {{16{im[15]}}, im};
        e.r = 32'd0; e.w = 1'b0; e.f = f; e.tag = tag;
        case (op[5:4])
            2'd0, 2'd1: begin
                l  = (op[5:4] == 2'd0) ? s0 : dv;
                r  = (op[5:4] == 2'd0) ? s1 : sx;
                eq = (l == r);
                lt = op[3] ? ($signed(l) < $signed(r)) : (l < r);
                case (op[2:0])
                    3'd0: e.f = eq;
                    3'd1: e.f = !eq;
                    3'd2: e.f = !lt && !eq;
                    3'd3: e.f = !lt;
                    3'd4: e.f = lt;
                    3'd5: e.f = lt || eq;
                    default: e.f = 1'b0;
                endcase
            end
            2'd2: begin
                pos = op[1] ? int'(s1[5:0]) : int'(s1[4:0]);
                b   = (pos >= 32) ? s0h[pos-32] : s0[pos];
                e.f = op[0] ? b : !b;
            end
            default: begin
                case (op[1:0])
                    2'd0: begin e.r = sx; e.w = 1'b1; end
                    2'd1: begin e.r = f ? sx : dv; e.w = f; end
                    2'd2: begin e.r = dv + sx; e.w = 1'b1; end
                    default: begin e.r = dv * sx; e.w = 1'b1; end
                endcase
            end
        endcase
        return e;
    endfunction

    task automatic drv(logic [5:0] op, logic [31:0] s0, logic [31:0] s0h, logic [31:0] s1,
                       logic [31:0] dv, logic [15:0] im, logic f, string tag);
        @(negedge clk);
        in_valid = 1'b1; op_code = op; src0 = s0; src0_hi = s0h; src1 = s1;
        dst_val = dv; imm_val = im; flag_in = f;
        q.push_back(model(op, s0, s0h, s1, dv, im, f, tag));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Scoreboard monitor: compares each produced result with the oldest expectation.
    always @(posedge clk) begin
        #1;
        if (!rst && out_valid) begin
            exp_t e;
            checks++;
            if (q.size() == 0) begin
                failures++;
                $display("FAIL R11 unexpected out_valid: actual=1 expected=0");
            end else begin
                e = q.pop_front();
                if (result !== e.r || wr_en !== e.w || flag_out !== e.f) begin
                    failures++;
                    $display("FAIL %s: actual r=%h w=%b f=%b expected r=%h w=%b f=%b",
                             e.tag, result, wr_en, flag_out, e.r, e.w, e.f);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; op_code = '0; src0 = '0; src0_hi = '0;
        src1 = '0; dst_val = '0; imm_val = '0; flag_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || wr_en !== 1'b0 || flag_out !== 1'b0 || result !== 32'd0) begin
            failures++;
            $display("FAIL R11 reset state: actual v=%b w=%b f=%b r=%h expected 0",
                     out_valid, wr_en, flag_out, result);
        end

        // R1 unsigned: 5 versus 0xFFFFFFFF, and an equal pair
        for (int c = 0; c < 6; c++)
            drv(opc(0, 0, c), 32'd5, 32'd0, 32'hFFFF_FFFF, 32'd0, 16'd0, 1'b0, "R1");
        for (int c = 0; c < 6; c++)
            drv(opc(0, 0, c), 32'd77, 32'd0, 32'd77, 32'd0, 16'd0, 1'b1, "R1");
        // R2 signed: same operands, -1 is now smaller
        for (int c = 0; c < 6; c++)
            drv(opc(0, 1, c), 32'd5, 32'd0, 32'hFFFF_FFFF, 32'd0, 16'd0, 1'b0, "R2");
        drv(opc(0, 1, 4), 32'h8000_0000, 32'd0, 32'h7FFF_FFFF, 32'd0, 16'd0, 1'b0, "R2");
        // R3 compare writes nothing even with a nonzero destination
        drv(opc(0, 0, 0), 32'd1, 32'd0, 32'd1, 32'hDEAD_BEEF, 16'h1234, 1'b1, "R3");
        // R12 reserved selects
        drv(opc(0, 0, 6), 32'd1, 32'd0, 32'd1, 32'd0, 16'd0, 1'b1, "R12");
        drv(opc(1, 1, 7), 32'd0, 32'd0, 32'd0, 32'd3, 16'd3, 1'b1, "R12");
        // R4 32-bit bit test, position masked to 5 bits
        drv(opc(2, 0, 1), 32'h8000_0000, 32'd0, 32'h3F, 32'd0, 16'd0, 1'b0, "R4");
        drv(opc(2, 0, 0), 32'h8000_0000, 32'd0, 32'h3F, 32'd0, 16'd0, 1'b0, "R4");
        drv(opc(2, 0, 0), 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'h20, 32'd0, 16'd0, 1'b0, "R4");
        // R5 64-bit bit test
        drv(opc(2, 0, 3), 32'd0, 32'd2, 32'd33, 32'd0, 16'd0, 1'b0, "R5");
        drv(opc(2, 0, 3), 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'd63, 32'd0, 16'd0, 1'b1, "R5");
        drv(opc(2, 0, 2), 32'h0000_0020, 32'd0, 32'h45, 32'd0, 16'd0, 1'b1, "R5");
        // R6 immediate compares, sign extension in unsigned form
        drv(opc(1, 0, 0), 32'd0, 32'd0, 32'd0, 32'hFFFF_FFFF, 16'hFFFF, 1'b0, "R6");
        drv(opc(1, 0, 2), 32'd0, 32'd0, 32'd0, 32'd1, 16'h8000, 1'b0, "R6");
        drv(opc(1, 1, 2), 32'd0, 32'd0, 32'd0, 32'd1, 16'h8000, 1'b0, "R6");
        drv(opc(1, 0, 4), 32'd9, 32'd0, 32'd1, 32'd1, 16'h0002, 1'b0, "R6");
        // R7 move
        drv(opc(3, 0, 0), 32'd0, 32'd0, 32'd0, 32'd55, 16'h8001, 1'b1, "R7");
        // R8 conditional move both ways
        drv(opc(3, 0, 1), 32'd0, 32'd0, 32'd0, 32'h1111_2222, 16'h7FFF, 1'b1, "R8");
        drv(opc(3, 0, 1), 32'd0, 32'd0, 32'd0, 32'h1111_2222, 16'h7FFF, 1'b0, "R8");
        // R9 add and multiply
        drv(opc(3, 0, 2), 32'd0, 32'd0, 32'd0, 32'd10, 16'hFFFE, 1'b0, "R9");
        drv(opc(3, 0, 3), 32'd0, 32'd0, 32'd0, 32'd3, 16'hFFFF, 1'b0, "R9");
        drv(opc(3, 0, 3), 32'd0, 32'd0, 32'd0, 32'h0001_0000, 16'h0100, 1'b1, "R9");
        // R10 flag passes through writes
        drv(opc(3, 0, 2), 32'd0, 32'd0, 32'd0, 32'd1, 16'd1, 1'b1, "R10");
        drv(opc(3, 0, 0), 32'd0, 32'd0, 32'd0, 32'd1, 16'd1, 1'b0, "R10");

        idle();
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || wr_en !== 1'b0) begin
            failures++;
            $display("FAIL R11 idle: actual v=%b w=%b expected v=0 w=0", out_valid, wr_en);
        end

        for (int i = 0; i < 300; i++) begin
            logic [5:0] op;
            string t;
            op = 6'($urandom);
            case (op[5:4])
                2'd0: t = op[3] ? "R2" : "R1";
                2'd1: t = "R6";
                2'd2: t = op[1] ? "R5" : "R4";
                default: t = (op[1:0] == 2'd0) ? "R7" : (op[1:0] == 2'd1) ? "R8" : "R9";
            endcase
            drv(op, $urandom, $urandom, $urandom, $urandom, 16'($urandom), 1'($urandom), t);
        end
        idle();
        repeat (3) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            failures++;
            $display("FAIL R11 missing results: actual=%0d expected=0", q.size());
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule